// File: doc/BRIEF.md
# Duplicate TLB Entry Scrubber

This block repairs a translation buffer after the lookup logic has reported that one address matched more than one way of a set. When `start` is pulsed it first turns translation back on by setting the top bit of the address-space register. It then reads out every entry, one set at a time, through the TLB's indexed register port. Within each set it removes entries whose virtual page numbers collide.

The buffer storage sits outside this block and is reached only through a small register port. The port has an address-space register, an index register, two descriptor words (tag word and data word) and a command register. A read command copies the entry selected by the index into the two descriptor words. A write command stores the two descriptor words into the entry selected by the index. The scrubber issues one port access per cycle. Read data returns combinationally in the same cycle.

When the walk finishes, the block raises `done` for one cycle. It also reports how many entries it erased and where the first erased entry was.

Top module: `tlb_dup_scrub`

## Requirements
- R1: After `start`, the scrubber reads register address 0 (address-space register) and writes it back with bit 31 set and bits 30:0 unchanged, before any other port access.
- R2: Each entry is fetched in this order: write address 1 (index) with set*WAYS+way, write address 4 (command) with value 2 (read), read address 2 (tag word), read address 3 (data word). Sets are walked in ascending order and ways in ascending order within a set, so the index values issued with read commands are 0, 1, 2 and so on up to SETS*WAYS-1.
- R3: A set in which no fetched tag word has bit PRESENT_BIT (default 10) set causes no erase, even when its page numbers collide.
- R4: A way whose fetched tag word is all zeros is never the first operand of a comparison, so it is never erased on account of a later way.
- R5: Two ways match when tag-word bits 31:VPN_LSB (default 31:13) are equal. The remaining low bits are ignored.
- R6: Way w is compared with every way n > w. On a match, way w (the lower one) is erased, never way n. Its local copy is then cleared, so it takes part in no further match.
- R7: Erasing an entry writes address 1 with its index, then address 2 with zero, then address 3 with zero, then address 4 with value 1 (write), in that order.
- R8: After the last set, `done` is high for exactly one cycle. At that point `dup_count` holds the number of erases in this run, and `first_set`/`first_way` hold the location of the first erase (zero when there was none).
- R9: `start` has no effect while `busy` is high. No second walk follows and only one `done` pulse appears.
- R10: WAYS is a parameter from 1 to 4, and SETS a parameter of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scrub (ignored while busy) |
| busy | output | 1 | Scrub in progress |
| done | output | 1 | One-cycle completion pulse |
| dup_count | output | CNT_W | Entries erased in the last run |
| first_set | output | SET_W | Set of the first erased entry |
| first_way | output | 2 | Way of the first erased entry |
| aux_we | output | 1 | Register port write strobe |
| aux_re | output | 1 | Register port read strobe |
| aux_addr | output | 3 | Register select: 0 address space, 1 index, 2 tag word, 3 data word, 4 command |
| aux_wdata | output | 32 | Register write data |
| aux_rdata | input | 32 | Register read data, valid in the cycle of `aux_re` |

## Verification
The assertions assume that the register port executes each access in the cycle it is presented. They also assume that `aux_rdata` for the tag word reflects a read command issued in an earlier cycle. The bench meets this with a cycle-exact model of the storage that applies writes and commands at the clock edge and returns reads combinationally.

Stimulus loads the storage only while the scrubber is idle. It pulses `start` away from the clock edge. The only `start` raised during a walk is the deliberate one used to exercise R9.

// File: rtl/tlb_dup_scrub.sv
module tlb_dup_scrub #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int VPN_LSB = 13,
  parameter int PRESENT_BIT = 10,
  localparam int ENT = SETS * WAYS,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int CNT_W = $clog2(ENT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] dup_count,
  output logic [SET_W-1:0] first_set,
  output logic [1:0]       first_way,
  output logic             aux_we,
  output logic             aux_re,
  output logic [2:0]       aux_addr,
  output logic [31:0]      aux_wdata,
  input  logic [31:0]      aux_rdata
);
  localparam logic [2:0] A_PID = 3'd0, A_IDX = 3'd1, A_PD0 = 3'd2, A_PD1 = 3'd3, A_CMD = 3'd4;
  localparam logic [31:0] C_WRITE = 32'd1, C_READ = 32'd2;

  typedef enum logic [3:0] {
    IDLE, PID_RD, PID_WR, R_IDX, R_CMD, R_PD0, R_PD1,
    CHK, CMP, E_IDX, E_PD0, E_PD1, E_CMD, FIN
  } st_t;

  st_t              st;
  logic [31:0]      pid_q;
  logic [SET_W-1:0] set_q;
  logic [1:0]       way_q, w_q, n_q;
  logic [31:0]      pd0_q [4];
  logic             any_pres;

  always_comb begin
    any_pres = 1'b0;
    for (int i = 0; i < WAYS; i++) any_pres = any_pres | pd0_q[i][PRESENT_BIT];
  end

  wire        hit      = (pd0_q[w_q] != 32'd0) &&
                         (pd0_q[w_q][31:VPN_LSB] == pd0_q[n_q][31:VPN_LSB]);
  wire        last_n   = int'(n_q) == WAYS - 1;
  wire        last_w   = int'(w_q) + 1 >= WAYS - 1;
  wire        last_set = int'(set_q) == SETS - 1;
  wire        last_way = int'(way_q) == WAYS - 1;
  wire [1:0]  idx_way  = (st == E_IDX) ? w_q : way_q;
  wire [31:0] idx_val  = 32'(set_q) * 32'(WAYS) + 32'(idx_way);

  assign busy = st != IDLE;
  assign done = st == FIN;
  assign aux_re = st inside {PID_RD, R_PD0, R_PD1};
  assign aux_we = st inside {PID_WR, R_IDX, R_CMD, E_IDX, E_PD0, E_PD1, E_CMD};

  always_comb begin
    aux_addr  = A_PID;
    aux_wdata = 32'd0;
    case (st)
      PID_WR:       aux_wdata = pid_q | 32'h8000_0000;
      R_IDX, E_IDX: begin aux_addr = A_IDX; aux_wdata = idx_val; end
      R_CMD:        begin aux_addr = A_CMD; aux_wdata = C_READ; end
      E_CMD:        begin aux_addr = A_CMD; aux_wdata = C_WRITE; end
      R_PD0, E_PD0: aux_addr = A_PD0;
      R_PD1, E_PD1: aux_addr = A_PD1;
      default:      aux_addr = A_PID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      pid_q <= '0;
      set_q <= '0;
      way_q <= '0;
      w_q <= '0;
      n_q <= '0;
      dup_count <= '0;
      first_set <= '0;
      first_way <= '0;
      for (int i = 0; i < 4; i++) pd0_q[i] <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          dup_count <= '0;
          first_set <= '0;
          first_way <= '0;
          st <= PID_RD;
        end
        PID_RD: begin pid_q <= aux_rdata; st <= PID_WR; end
        PID_WR: begin set_q <= '0; way_q <= '0; st <= R_IDX; end
        R_IDX:  st <= R_CMD;
        R_CMD:  st <= R_PD0;
        R_PD0:  begin pd0_q[way_q] <= aux_rdata; st <= R_PD1; end
        R_PD1:  if (last_way) st <= CHK;
                else begin way_q <= way_q + 2'd1; st <= R_IDX; end
        CHK: begin
          w_q <= 2'd0;
          n_q <= 2'd1;
          if (any_pres && WAYS > 1) st <= CMP;
          else if (last_set) st <= FIN;
          else begin set_q <= set_q + 1'b1; way_q <= '0; st <= R_IDX; end
        end
        CMP: begin
          if (hit) st <= E_IDX;
          else if (!last_n) n_q <= n_q + 2'd1;
          else if (!last_w) begin w_q <= w_q + 2'd1; n_q <= w_q + 2'd2; end
          else if (last_set) st <= FIN;
          else begin set_q <= set_q + 1'b1; way_q <= '0; st <= R_IDX; end
        end
        E_IDX: st <= E_PD0;
        E_PD0: st <= E_PD1;
        E_PD1: st <= E_CMD;
        E_CMD: begin
          pd0_q[w_q] <= '0;
          dup_count <= dup_count + 1'b1;
          if (dup_count == '0) begin first_set <= set_q; first_way <= w_q; end
          st <= CMP;
        end
        FIN:     st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlb_dup_scrub_chk.sv
module tlb_dup_scrub_chk #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int ENT = SETS * WAYS,
  localparam int CNT_W = $clog2(ENT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] dup_count,
  input logic             aux_we,
  input logic             aux_re,
  input logic [2:0]       aux_addr,
  input logic [31:0]      aux_wdata
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R1
  pid_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_we && aux_addr == 3'd0) |-> aux_wdata[31]);
  // R7
  erase_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_we && aux_addr == 3'd4 && aux_wdata == 32'd1) |->
    $past(aux_we && aux_addr == 3'd3 && aux_wdata == 32'd0));
  // R7
  erase_pd1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_we && aux_addr == 3'd3) |->
    (aux_wdata == 32'd0 && $past(aux_we && aux_addr == 3'd2 && aux_wdata == 32'd0)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!aux_we && !aux_re));
  // R8
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> dup_count >= $past(dup_count));
  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(aux_we && aux_re));
endmodule

bind tlb_dup_scrub tlb_dup_scrub_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/sim_tlb_dup_scrub.sv
`timescale 1ns/1ps
module sim_tlb_dup_scrub;
  localparam int SETS = 8, WAYS = 4, ENT = SETS * WAYS;
  localparam int SET_W = $clog2(SETS), CNT_W = $clog2(ENT + 1);
  localparam int VL = 13, PB = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, aux_we, aux_re;
  logic [CNT_W-1:0] dup_count;
  logic [SET_W-1:0] first_set;
  logic [1:0] first_way;
  logic [2:0] aux_addr;
  logic [31:0] aux_wdata, aux_rdata;

  always #4 clk = ~clk;

  tlb_dup_scrub u0 (.*);

  logic [31:0] ent0 [ENT];
  logic [31:0] ent1 [ENT];
  logic [31:0] exp0 [ENT];
  logic [31:0] m_pid, m_idx, m_pd0, m_pd1;
  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int exp_cnt, exp_fs, exp_fw, rd_ctr, done_ctr;

  always_comb begin
    case (aux_addr)
      3'd0: aux_rdata = m_pid;
      3'd1: aux_rdata = m_idx;
      3'd2: aux_rdata = m_pd0;
      3'd3: aux_rdata = m_pd1;
      default: aux_rdata = 32'd0;
    endcase
  end

  always @(posedge clk) if (aux_we) begin
    case (aux_addr)
      3'd0: m_pid <= aux_wdata;
      3'd1: m_idx <= aux_wdata;
      3'd2: m_pd0 <= aux_wdata;
      3'd3: m_pd1 <= aux_wdata;
      3'd4: if (aux_wdata == 32'd2) begin
              m_pd0 <= ent0[m_idx]; m_pd1 <= ent1[m_idx];
            end else if (aux_wdata == 32'd1) begin
              ent0[m_idx] <= m_pd0; ent1[m_idx] <= m_pd1;
            end
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected erases, checks read order
  always @(negedge clk) if (rst_n) begin
    if (done) done_ctr++;
    if (aux_we && aux_addr == 3'd4 && aux_wdata == 32'd2) begin
      chk(m_idx == 32'(rd_ctr), "R2 read index", int'(m_idx), rd_ctr);
      rd_ctr++;
    end
    if (aux_we && aux_addr == 3'd4 && aux_wdata == 32'd1) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected erase", int'(m_idx), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(m_idx == 32'(e), "R6 erase index", int'(m_idx), e);
        chk(m_pd0 == 0 && m_pd1 == 0, "R7 erase words zero", int'(m_pd0 | m_pd1), 0);
      end
    end
  end

  task automatic build_ref();
    logic [31:0] cp [4];
    bit any;
    exp_q.delete();
    exp_cnt = 0; exp_fs = 0; exp_fw = 0;
    for (int i = 0; i < ENT; i++) exp0[i] = ent0[i];
    for (int s = 0; s < SETS; s++) begin
      any = 0;
      for (int w = 0; w < WAYS; w++) begin cp[w] = ent0[s*WAYS+w]; any |= cp[w][PB]; end
      if (!any) continue;
      for (int w = 0; w < WAYS; w++)
        for (int n = w + 1; n < WAYS; n++)
          if (cp[w] != 0 && cp[w][31:VL] == cp[n][31:VL]) begin
            exp_q.push_back(s*WAYS+w);
            if (exp_cnt == 0) begin exp_fs = s; exp_fw = w; end
            exp_cnt++;
            cp[w] = 0;
            exp0[s*WAYS+w] = 0;
          end
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < ENT; i++) begin ent0[i] = 0; ent1[i] = 32'h1000 + i; end
  endtask

  function automatic logic [31:0] pd(input int vpn, input bit p, input int asid);
    return (32'(vpn) << VL) | (32'(p) << PB) | 32'(asid & 8'hff);
  endfunction

  task automatic run(input int hard_cnt, input string tag, input bit restart);
    int cyc;
    build_ref();
    chk(exp_cnt == hard_cnt, {tag, " reference count"}, exp_cnt, hard_cnt);
    rd_ctr = 0; done_ctr = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!done) chk(0, {tag, " R8 watchdog"}, cyc, 0);
    else begin
      chk(int'(dup_count) == exp_cnt, {tag, " R8 count"}, int'(dup_count), exp_cnt);
      chk(int'(first_set) == exp_fs && int'(first_way) == exp_fw, {tag, " R8 first"},
          int'(first_set) * 4 + int'(first_way), exp_fs * 4 + exp_fw);
    end
    repeat (20) @(negedge clk);
    chk(done_ctr == 1, {tag, " R9 one done"}, done_ctr, 1);
    chk(rd_ctr == ENT, {tag, " R2 read total"}, rd_ctr, ENT);
    chk(exp_q.size() == 0, {tag, " R6 erases pending"}, exp_q.size(), 0);
    begin
      int bad = 0;
      for (int i = 0; i < ENT; i++) if (ent0[i] != exp0[i]) bad++;
      chk(bad == 0, {tag, " R6 final table"}, bad, 0);
    end
  endtask

  initial begin
    m_pid = 32'h0000_00a5; m_idx = 0; m_pd0 = 0; m_pd1 = 0;
    clear_tbl();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && dup_count == 0, "R8 reset state", {busy, done}, 0);
    chk(!aux_we && !aux_re, "R9 idle port quiet", {aux_we, aux_re}, 0);

    // T1: colliding page numbers with no present bit anywhere (R3)
    for (int w = 0; w < WAYS; w++) ent0[1*WAYS+w] = pd(7, 0, w + 1);
    run(0, "T1 R3", 0);
    chk(m_pid == 32'h8000_00a5, "R1 pid enable", int'(m_pid), 32'h8000_00a5);

    // T2: lower-way erase, zero first operand, low bits ignored (R4 R5 R6 R10)
    clear_tbl();
    ent0[2*WAYS+0] = pd(5, 1, 1); ent0[2*WAYS+2] = pd(5, 1, 2); ent0[2*WAYS+3] = pd(5, 1, 3);
    ent0[3*WAYS+1] = pd(0, 1, 4); ent0[3*WAYS+2] = pd(9, 1, 4); ent0[3*WAYS+3] = pd(11, 1, 4);
    ent0[4*WAYS+0] = pd(6, 1, 1); ent0[4*WAYS+1] = pd(6, 0, 7) | 32'h1f00;
    ent0[7*WAYS+1] = pd(12, 1, 2); ent0[7*WAYS+3] = pd(13, 1, 2);
    run(3, "T2 R4 R5", 0);
    chk(ent0[2*WAYS+3] == pd(5, 1, 3), "R6 higher way kept", int'(ent0[2*WAYS+3]), int'(pd(5, 1, 3)));
    chk(ent0[3*WAYS+1] == pd(0, 1, 4), "R4 zero way skipped", int'(ent0[3*WAYS+1]), int'(pd(0, 1, 4)));

    // T3: triple match, last set, start while busy (R9)
    clear_tbl();
    ent0[1] = pd(3, 1, 1); ent0[2] = pd(3, 1, 2); ent0[3] = pd(3, 1, 3);
    ent0[(SETS-1)*WAYS+0] = pd(8, 1, 1); ent0[(SETS-1)*WAYS+3] = pd(8, 1, 9);
    run(3, "T3 R9", 1);
    chk(!busy, "R9 idle after run", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule